// File: doc/BRIEF.md
# Character Transmit Scheduler

This block runs in the parallel-clock domain in front of a line encoder that sends one 10-bit character per transfer cycle. A character is an 8-bit payload with a 2-bit type header in front of it. A free-running beat counter marks the start of each transfer cycle. The cycle lasts 5 clocks when the encoder carries two payload bits per clock, or 10 clocks when it carries one.

On each beat the scheduler picks one character from three sources and latches it for the encoder:

- a user request, which is either a K (link control) or a D (data) character;
- an internal T (transceiver control) request;
- the idle character, when nothing is requested.

The winning source gets an acknowledge in the beat cycle. A source that loses keeps its request asserted and competes again on the next beat.

Top module: `char_tx_sched`

## Requirements
- R1: `char_out[9:8]` carries the type header and `char_out[7:0]` carries the payload. The headers are D = 2'b01, K = 2'b10, T = 2'b11 and idle = 2'b00. The idle character is 10'h000.
- R2: The transfer period N is set by parameter `BITS_PER_CLK`. With the value 2, N is 5 clocks. With the value 1, N is 10 clocks.
- R3: `beat` is high for exactly one cycle in every N cycles. The counter is 0 out of reset, so the first beat is high in the cycle after the (N-1)th rising edge that sees `rst_n` high.
- R4: `usr_ack` and `ctl_ack` are high only in a beat cycle. They go high in the same cycle as `beat`, for the request that is latched on that edge.
- R5: Priority is K over T over D. When `ctl_valid` is high on a beat, a D request is not acknowledged. When a K request is present, a T request is not acknowledged.
- R6: A user request is sent as a K character when `usr_is_k` is 1 and as a D character when it is 0.
- R7: When no request is valid on a beat, the idle character is latched and `char_idle` is high for the following period.
- R8: At most one request is acknowledged per beat. A request held until its acknowledge is sent exactly once, so nothing is dropped and nothing is duplicated.
- R9: While `rst_n` is low at a rising edge, the counter clears, `char_out` becomes idle, and `beat` and both acknowledges read 0.
- R10: `char_out` changes only on the rising edge that ends a beat cycle, and holds its value for the rest of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| usr_valid | input | 1 | User request pending |
| usr_is_k | input | 1 | 1: send user byte as K, 0: as D |
| usr_data | input | 8 | User payload byte |
| usr_ack | output | 1 | User request latched on this beat |
| ctl_valid | input | 1 | Internal T request pending |
| ctl_data | input | 8 | T payload byte |
| ctl_ack | output | 1 | T request latched on this beat |
| beat | output | 1 | One-cycle transfer boundary marker |
| char_out | output | 10 | Character presented to the encoder |
| char_idle | output | 1 | Current character is idle |

## Verification
The assertions take for granted that any requester which sees no acknowledge keeps its valid, type and payload unchanged into the next cycle. Two assertions, one per source, check exactly this. The bench changes a request only on the falling edge after the edge that latched it, so a request is never withdrawn or altered before its acknowledge. For the same reason, the one-per-beat and priority checks can rely on the set of pending requests being fixed over a whole period.

// File: rtl/char_tx_pkg.sv
// Package: shared character widths, type headers and a packing helper for
// the transmit scheduler. Assumes an 8-bit payload and a 2-bit header.
package char_tx_pkg;

    localparam int DATA_W = 8;
    localparam int HDR_W  = 2;
    localparam int CHAR_W = DATA_W + HDR_W;

    typedef enum logic [HDR_W-1:0] {
        HDR_IDLE = 2'b00,
        HDR_D    = 2'b01,
        HDR_K    = 2'b10,
        HDR_T    = 2'b11
    } char_hdr_e;

    // Pack a header and a payload into one character word.
    function automatic logic [CHAR_W-1:0] pack_char(input char_hdr_e hdr,
                                                    input logic [DATA_W-1:0] data);
        return {hdr, data};
    endfunction

endpackage

// File: rtl/char_beat_gen.sv
// Module: transfer-cycle beat counter. It counts 0..PERIOD-1 and raises
// beat for the single cycle in which the count is PERIOD-1.
// Assumes PERIOD >= 2 and a synchronous active-low reset.
module char_beat_gen #(
    parameter int PERIOD = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic beat
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Advance the period counter and wrap at the end of each character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Beat marks the last cycle of the transfer period.
    always_comb beat = (cnt_q == LAST);

    // Independent gap counter for checking the beat spacing.
    logic [CW:0] gap_q;

    // Count the cycles since reset or since the previous beat.
    always_ff @(posedge clk) begin
        if (!rst_n || beat)
            gap_q <= '0;
        else
            gap_q <= gap_q + 1'b1;
    end

    assert_beat_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> !beat);

    assert_beat_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (gap_q == (CW+1)'(PERIOD - 1)));

endmodule

// File: rtl/char_arbiter.sv
// Module: fixed-priority grant logic for one beat. K beats T and T beats D.
// Grants are given only in the beat cycle. Assumes requesters hold their
// request until granted.
module char_arbiter
    import char_tx_pkg::*;
(
    input  logic              beat,
    input  logic              usr_valid,
    input  logic              usr_is_k,
    input  logic [DATA_W-1:0] usr_data,
    input  logic              ctl_valid,
    input  logic [DATA_W-1:0] ctl_data,
    output logic              usr_ack,
    output logic              ctl_ack,
    output char_hdr_e         sel_hdr,
    output logic [DATA_W-1:0] sel_data
);
    logic k_req;
    logic t_req;
    logic d_req;

    // Split the user request into its K and D parts.
    always_comb begin
        k_req = usr_valid &&  usr_is_k;
        d_req = usr_valid && !usr_is_k;
        t_req = ctl_valid;
    end

    // Pick the winning source and its character for this beat.
    always_comb begin
        usr_ack  = 1'b0;
        ctl_ack  = 1'b0;
        sel_hdr  = HDR_IDLE;
        sel_data = '0;
        if (k_req) begin
            sel_hdr  = HDR_K;
            sel_data = usr_data;
            usr_ack  = beat;
        end else if (t_req) begin
            sel_hdr  = HDR_T;
            sel_data = ctl_data;
            ctl_ack  = beat;
        end else if (d_req) begin
            sel_hdr  = HDR_D;
            sel_data = usr_data;
            usr_ack  = beat;
        end
    end

endmodule

// File: rtl/char_latch.sv
// Module: character holding register. It loads a new character on a beat and
// holds it for the whole transfer period. It resets to the idle character.
module char_latch
    import char_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  char_hdr_e         hdr,
    input  logic [DATA_W-1:0] data,
    output logic [CHAR_W-1:0] char_q,
    output logic              idle
);
    // Capture the selected character at the transfer boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            char_q <= pack_char(HDR_IDLE, '0);
        else if (load)
            char_q <= pack_char(hdr, data);
    end

    // Flag the idle character from its header.
    always_comb idle = (char_q[CHAR_W-1 -: HDR_W] == HDR_IDLE);

    assert_char_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(char_q));

endmodule

// File: rtl/char_tx_sched.sv
// Module: top of the character transmit scheduler. It combines the beat
// counter, the priority arbiter and the character register.
// Assumes each requester keeps valid, type and data stable until acknowledged.
module char_tx_sched
    import char_tx_pkg::*;
#(
    parameter int BITS_PER_CLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_valid,
    input  logic              usr_is_k,
    input  logic [DATA_W-1:0] usr_data,
    output logic              usr_ack,
    input  logic              ctl_valid,
    input  logic [DATA_W-1:0] ctl_data,
    output logic              ctl_ack,
    output logic              beat,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_idle
);
    localparam int PERIOD = (BITS_PER_CLK == 1) ? CHAR_W : (CHAR_W / 2);

    char_hdr_e         sel_hdr;
    logic [DATA_W-1:0] sel_data;

    char_beat_gen #(.PERIOD(PERIOD)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat)
    );

    char_arbiter u_arb (
        .beat      (beat),
        .usr_valid (usr_valid),
        .usr_is_k  (usr_is_k),
        .usr_data  (usr_data),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .usr_ack   (usr_ack),
        .ctl_ack   (ctl_ack),
        .sel_hdr   (sel_hdr),
        .sel_data  (sel_data)
    );

    char_latch u_char (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (beat),
        .hdr    (sel_hdr),
        .data   (sel_data),
        .char_q (char_out),
        .idle   (char_idle)
    );

    assert_ack_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_ack || ctl_ack) |-> beat);

    assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({usr_ack, ctl_ack}) <= 1);

    assert_t_blocks_d_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && ctl_valid && usr_valid && !usr_is_k) |-> (ctl_ack && !usr_ack));

    assert_k_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_ack && usr_is_k) |=> (char_out[CHAR_W-1 -: HDR_W] == 2'b10));

    assert_idle_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !usr_valid && !ctl_valid) |=> char_idle);

    assert_usr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_valid && !usr_ack) |=> (usr_valid && $stable(usr_data) && $stable(usr_is_k)));

    assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_ack) |=> (ctl_valid && $stable(ctl_data)));

endmodule

// File: tb/char_tx_sched_tb.sv
module char_tx_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       u_valid = 1'b0, u_k = 1'b0, c_valid = 1'b0;
    logic [7:0] u_data = 8'h00, c_data = 8'h00;
    logic       u_ack, c_ack, beat, idle;
    logic [9:0] ch;
    logic       s_valid = 1'b0, s_k = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_ack, s_cack, s_beat, s_idle;
    logic [9:0] s_ch;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    char_tx_sched #(.BITS_PER_CLK(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .usr_valid(u_valid), .usr_is_k(u_k),
        .usr_data(u_data), .usr_ack(u_ack), .ctl_valid(c_valid), .ctl_data(c_data),
        .ctl_ack(c_ack), .beat(beat), .char_out(ch), .char_idle(idle));

    char_tx_sched #(.BITS_PER_CLK(1)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .usr_valid(s_valid), .usr_is_k(s_k),
        .usr_data(s_data), .usr_ack(s_ack), .ctl_valid(1'b0), .ctl_data(8'h00),
        .ctl_ack(s_cack), .beat(s_beat), .char_out(s_ch), .char_idle(s_idle));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Step falling edges until the fast lane beats; acks off-beat are errors.
    task automatic wait_beat();
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!beat && (u_ack || c_ack)) chk("R4 ack off beat", 1, 0);
            if (beat) return;
        end
        chk("R3 beat missing", 0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9 beat in reset", beat, 0);
        chk("R9 ack in reset", {u_ack, c_ack}, 0);
        chk("R9 char in reset", ch, 10'h000);
        chk("R9 idle in reset", idle, 1);
    endtask

    task automatic t_first_beat();
        int first_f = 0, first_s = 0, nxt = 0;
        rst_n = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (beat && first_f == 0) first_f = k;
            if (s_beat && first_s == 0) first_s = k;
        end
        chk("R3 first beat fast", first_f, 4);
        chk("R2 first beat slow", first_s, 9);
        wait_beat();
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (beat) begin nxt = k; break; end
        end
        chk("R2 fast period", nxt, 5);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (s_beat) break;
        end
        nxt = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (s_beat) begin nxt = k; break; end
        end
        chk("R2 slow period", nxt, 10);
    endtask

    task automatic t_send(input bit is_k, input logic [7:0] d, input string req);
        u_valid = 1'b1; u_k = is_k; u_data = d;
        wait_beat();
        chk({req, " ack"}, u_ack, 1);
        @(negedge clk);
        chk({req, " char"}, ch, {is_k ? 2'b10 : 2'b01, d});
        chk({req, " idle flag"}, idle, 0);
        u_valid = 1'b0;
    endtask

    task automatic t_idle();
        wait_beat();
        chk("R7 no ack", {u_ack, c_ack}, 0);
        @(negedge clk);
        chk("R7 idle char", ch, 10'h000);
        chk("R7 idle flag", idle, 1);
    endtask

    task automatic t_t_over_d();
        logic [9:0] held;
        c_valid = 1'b1; c_data = 8'h3C;
        u_valid = 1'b1; u_k = 1'b0; u_data = 8'h11;
        wait_beat();
        chk("R5 T ack", c_ack, 1);
        chk("R5 D held", u_ack, 0);
        @(negedge clk);
        chk("R1 T char", ch, {2'b11, 8'h3C});
        c_valid = 1'b0;
        held = ch;
        @(negedge clk); @(negedge clk);
        chk("R10 char stable", ch, held);
        wait_beat();
        chk("R8 D after T", u_ack, 1);
        @(negedge clk);
        chk("R1 D char", ch, {2'b01, 8'h11});
        u_valid = 1'b0;
    endtask

    task automatic t_k_over_t();
        c_valid = 1'b1; c_data = 8'h77;
        u_valid = 1'b1; u_k = 1'b1; u_data = 8'hE1;
        wait_beat();
        chk("R5 K ack", u_ack, 1);
        chk("R5 T held", c_ack, 0);
        @(negedge clk);
        chk("R6 K char", ch, {2'b10, 8'hE1});
        u_valid = 1'b0;
        wait_beat();
        chk("R8 T after K", c_ack, 1);
        @(negedge clk);
        chk("R1 T char late", ch, {2'b11, 8'h77});
        c_valid = 1'b0;
    endtask

    task automatic t_stream();
        logic [7:0] seq [3] = '{8'h01, 8'h82, 8'hFF};
        for (int i = 0; i < 3; i++) begin
            u_valid = 1'b1; u_k = 1'b0; u_data = seq[i];
            wait_beat();
            chk("R8 stream ack", u_ack, 1);
            @(negedge clk);
            chk("R8 stream char", ch, {2'b01, seq[i]});
        end
        u_valid = 1'b0;
        wait_beat();
        chk("R8 no duplicate", u_ack, 0);
        @(negedge clk);
        chk("R8 idle after stream", ch, 10'h000);
    endtask

    task automatic t_slow();
        s_valid = 1'b1; s_k = 1'b1; s_data = 8'hC3;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (s_beat) break;
        end
        chk("R2 slow ack", s_ack, 1);
        @(negedge clk);
        chk("R6 slow K char", s_ch, {2'b10, 8'hC3});
        s_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_first_beat();
        t_send(1'b0, 8'h5A, "R6 D");
        t_send(1'b1, 8'hA5, "R6 K");
        t_idle();
        t_t_over_d();
        t_k_over_t();
        t_stream();
        t_slow();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule